// File: doc/BRIEF.md
# Per-Lane Variable Bidirectional Shifter

This block shifts every lane of a vector operand A by an amount that the matching lane of a second vector operand B supplies. The amount is the signed low byte of each B lane. A non-negative amount shifts the A lane left. A negative amount shifts it right by the magnitude, either arithmetically or logically depending on the signedness input. Lanes are 8, 16, 32 or 64 bits wide, and the vector is either the full 128 bits or only its low 64 bits.

An operand set is presented with `in_valid` high for one clock. The registered result appears on the next clock together with `out_valid`. The result register holds its value while no new operand set arrives. Any amount whose magnitude reaches or exceeds the lane width forces that lane to zero. This applies in both directions and in both modes, so software can use this block as a saturating-range shift without having to clamp the amount first.

Top module: `vshl_top`

## Requirements
- R1: The shift amount of a lane is bits [7:0] of the B lane, read as a two's-complement value from -128 to 127. All higher B bits of that lane have no effect.
- R2: An amount of zero or more shifts the A lane left by that amount and fills with zeros. An amount of zero returns the lane unchanged.
- R3: A negative amount shifts the A lane right by its magnitude. With `signed_mode`=1, copies of the lane's top bit fill from the left. With `signed_mode`=0, zeros fill from the left.
- R4: When the magnitude of the amount is greater than or equal to the lane width, the lane result is zero. This holds for left and right shifts and in both modes.
- R5: `lane_size` picks the lane width as 8 << `lane_size`: 0 gives 8 bits, 1 gives 16, 2 gives 32 and 3 gives 64. Lane i occupies bits [i*W +: W] of A, B and the result.
- R6: With `wide_reg`=0, result bits [127:64] are zero and only the low 64 bits are computed. With `wide_reg`=1, all 128 bits are computed.
- R7: Each lane is computed from its own A and B bits only. No bit moves across a lane boundary.
- R8: An amount of -128 (low byte 0x80) yields zero for every lane width.
- R9: The result and `out_valid` are registered. `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. While `in_valid` is low, `result` keeps its last value.
- R10: The synchronous, active-high `rst` clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand set present this cycle |
| vec_a | input | 128 | Data vector to be shifted |
| vec_b | input | 128 | Per-lane shift amount vector (low byte of each lane) |
| lane_size | input | 2 | Lane width code, width = 8 << code |
| signed_mode | input | 1 | 1: arithmetic right shift, 0: logical right shift |
| wide_reg | input | 1 | 1: 128-bit vector, 0: 64-bit vector with upper half zeroed |
| out_valid | output | 1 | Result valid this cycle |
| result | output | 128 | Registered shifted vector |

## Verification
The bench drives amounts that sit exactly on the lane width and one below it, in both directions. A design that compares with greater-than instead of greater-or-equal would return a lane shifted out by one bit, or a lane still holding sign copies, when it should return zero. The amount -128 is sent for every lane size: negating it in only eight bits wraps back to -128, so such a design would shift left by 128 or shift right by a truncated amount. Negative values under both signedness settings, B lanes with junk in their upper bytes, and alternating per-lane directions catch several faults. These are a wrong fill bit, an amount read from the wrong byte, and a shifter shared across lane boundaries. Random vectors across all sizes with the 64-bit register width catch an upper half that is not cleared.

// File: rtl/vshl_pkg.sv
package vshl_pkg;
  localparam int BASE_LANE_W = 8;
  localparam int AMT_W       = 8;

  function automatic int lane_width(input int size_code);
    return BASE_LANE_W << size_code;
  endfunction
endpackage

// File: rtl/vshl_lane.sv
// One lane: signed-byte amount, direction by sign, zero when out of range.
module vshl_lane #(
  parameter int LANE_W = 8,
  parameter int AMT_W  = 8
) (
  input  logic [LANE_W-1:0] a_i,
  input  logic [LANE_W-1:0] b_i,
  input  logic              sgn_i,
  output logic [LANE_W-1:0] y_o
);
  localparam int SH_W  = $clog2(LANE_W);
  localparam int MAG_W = AMT_W + 1;
  localparam logic [MAG_W-1:0] LIMIT = MAG_W'(LANE_W);
  localparam logic [MAG_W-1:0] ONE   = MAG_W'(1);

  logic [AMT_W-1:0] amt;
  logic             neg;
  logic [MAG_W-1:0] ext;
  logic [MAG_W-1:0] mag;
  logic             in_range;
  logic [SH_W-1:0]  sh;
  logic [LANE_W-1:0] left_v, right_l, right_a;

  assign amt = b_i[AMT_W-1:0];

  generate
    if (LANE_W > AMT_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^b_i[LANE_W-1:AMT_W];
    end
  endgenerate

  assign neg      = amt[AMT_W-1];
  assign ext      = {amt[AMT_W-1], amt};
  // nine-bit negation so that -128 becomes +128, not -128 again
  assign mag      = neg ? (~ext + ONE) : ext;
  assign in_range = (mag < LIMIT);
  assign sh       = mag[SH_W-1:0];

  assign left_v  = a_i << sh;
  assign right_l = a_i >> sh;
  assign right_a = $signed(a_i) >>> sh;

  always_comb begin
    if (!in_range)   y_o = '0;
    else if (!neg)   y_o = left_v;
    else if (sgn_i)  y_o = right_a;
    else             y_o = right_l;
  end
endmodule

// File: rtl/vshl_bank.sv
// All lanes of one lane width across the full vector.
module vshl_bank #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 8,
  parameter int AMT_W  = 8
) (
  input  logic [VEC_W-1:0] a_i,
  input  logic [VEC_W-1:0] b_i,
  input  logic             sgn_i,
  output logic [VEC_W-1:0] y_o
);
  localparam int NUM_LANES = VEC_W / LANE_W;

  generate
    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
      vshl_lane #(.LANE_W(LANE_W), .AMT_W(AMT_W)) lane_i (
        .a_i  (a_i[g*LANE_W +: LANE_W]),
        .b_i  (b_i[g*LANE_W +: LANE_W]),
        .sgn_i(sgn_i),
        .y_o  (y_o[g*LANE_W +: LANE_W])
      );
    end
  endgenerate
endmodule

// File: rtl/vshl_top.sv
module vshl_top #(
  parameter int VEC_W     = 128,
  parameter int NUM_SIZES = 4,
  parameter int SZ_W      = $clog2(NUM_SIZES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] vec_a,
  input  logic [VEC_W-1:0] vec_b,
  input  logic [SZ_W-1:0]  lane_size,
  input  logic             signed_mode,
  input  logic             wide_reg,
  output logic             out_valid,
  output logic [VEC_W-1:0] result
);
  localparam int HALF_W = VEC_W / 2;

  logic [VEC_W-1:0] bank_y [NUM_SIZES];
  logic [VEC_W-1:0] picked;
  logic [VEC_W-1:0] shaped;

  generate
    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_size
      vshl_bank #(
        .VEC_W (VEC_W),
        .LANE_W(vshl_pkg::lane_width(s)),
        .AMT_W (vshl_pkg::AMT_W)
      ) bank_i (
        .a_i  (vec_a),
        .b_i  (vec_b),
        .sgn_i(signed_mode),
        .y_o  (bank_y[s])
      );
    end
  endgenerate

  assign picked = bank_y[lane_size];
  assign shaped = wide_reg ? picked : {{HALF_W{1'b0}}, picked[HALF_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= shaped;
    end
  end
endmodule

// File: rtl/vshl_checker.sv
module vshl_checker #(
  parameter int VEC_W = 128,
  parameter int SZ_W  = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             in_valid,
  input logic [VEC_W-1:0] vec_a,
  input logic [VEC_W-1:0] vec_b,
  input logic [SZ_W-1:0]  lane_size,
  input logic             signed_mode,
  input logic             wide_reg,
  input logic             out_valid,
  input logic [VEC_W-1:0] result
);
  localparam logic [VEC_W-1:0] ALL_MIN = {(VEC_W/8){8'h80}};

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R9
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && $stable(result))); // R9
  AST_NARROW_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !wide_reg) |=> (result[VEC_W-1:VEC_W/2] == '0)); // R6
  AST_MIN_AMOUNT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vec_b == ALL_MIN) |=> (result == '0)); // R8
  AST_ZERO_AMOUNT_IDENT: assert property (@(posedge clk) disable iff (rst)
    (in_valid && wide_reg && vec_b == '0) |=> (result == $past(vec_a))); // R2
endmodule

bind vshl_top vshl_checker #(.VEC_W(VEC_W), .SZ_W(SZ_W)) chk_i (.*);

// File: tb/vshl_top_tb_top.sv
module vshl_top_tb_top;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] vec_a = '0;
  logic [127:0] vec_b = '0;
  logic [1:0]   lane_size = '0;
  logic         signed_mode = 1'b0;
  logic         wide_reg = 1'b1;
  logic         out_valid;
  logic [127:0] result;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  vshl_top dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .vec_a(vec_a), .vec_b(vec_b),
    .lane_size(lane_size), .signed_mode(signed_mode), .wide_reg(wide_reg),
    .out_valid(out_valid), .result(result)
  );

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input int sz, input bit sg, input bit wd);
    int w = 8 << sz;
    logic [127:0] acc = '0;
    logic [63:0] mask = (w == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << w) - 64'd1);
    for (int i = 0; i < 128 / w; i++) begin
      logic [63:0] va = 64'(a >> (i * w)) & mask;
      logic [63:0] vb = 64'(b >> (i * w));
      int amt = int'($signed(vb[7:0]));
      logic [63:0] r;
      if (sg && va[w-1]) va = va | ~mask;
      if (amt >= 0) r = (amt >= w) ? 64'd0 : (va << amt);
      else if (-amt >= w) r = 64'd0;
      else if (sg) r = 64'($signed(va) >>> (-amt));
      else r = va >> (-amt);
      acc = acc | (128'(r & mask) << (i * w));
    end
    if (!wd) acc[127:64] = '0;
    return acc;
  endfunction

  task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input string req, input logic [127:0] a, input logic [127:0] b,
                       input int sz, input bit sg, input bit wd, input logic [127:0] exp);
    @(negedge clk);
    vec_a = a; vec_b = b; lane_size = 2'(sz); signed_mode = sg; wide_reg = wd;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 128'(out_valid), 128'd1);
    check(req, result, exp);
  endtask

  task automatic apply_m(input string req, input logic [127:0] a, input logic [127:0] b,
                         input int sz, input bit sg, input bit wd);
    apply(req, a, b, sz, sg, wd, model(a, b, sz, sg, wd));
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] rnd_amounts();
    logic [127:0] v;
    for (int k = 0; k < 16; k++)
      v[k*8 +: 8] = ($urandom % 4 == 0) ? 8'($urandom) : 8'(int'($urandom % 141) - 70);
    return v;
  endfunction

  initial begin
    logic [127:0] held;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    check("R10 reset valid", 128'(out_valid), 128'd0);
    check("R10 reset result", result, '0);
    rst = 1'b0;

    apply("R2 left by 3", 128'h81, {16{8'd3}}, 0, 1'b0, 1'b1, 128'h08);
    apply("R2 zero amount", 128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6978, '0, 2, 1'b1, 1'b1,
          128'h1234_5678_9ABC_DEF0_0F1E_2D3C_4B5A_6978);
    apply("R3 arith right", {64'd0, 64'h8000_0000_0000_0000}, {64'd0, 64'hABCD_EF01_2345_67FC},
          3, 1'b1, 1'b1, {64'd0, 64'hF800_0000_0000_0000});
    apply("R3 logical right", {64'd0, 64'h8000_0000_0000_0000}, {64'd0, 64'hABCD_EF01_2345_67FC},
          3, 1'b0, 1'b1, {64'd0, 64'h0800_0000_0000_0000});
    apply("R4 left at width", {96'd0, 32'hFFFF_FFFF}, 128'h20, 2, 1'b0, 1'b1, '0);
    apply("R4 right at width signed", {96'd0, 32'hFFFF_FFFF}, 128'hE0, 2, 1'b1, 1'b1, '0);
    apply("R4 left width-1", {96'd0, 32'hFFFF_FFFF}, 128'h1F, 2, 1'b0, 1'b1, 128'h8000_0000);
    apply("R4 right width-1 signed", {96'd0, 32'hFFFF_FFFF}, 128'hE1, 2, 1'b1, 1'b1, 128'hFFFF_FFFF);
    apply("R4 right width-1 unsigned", {96'd0, 32'hFFFF_FFFF}, 128'hE1, 2, 1'b0, 1'b1, 128'h1);
    for (int s = 0; s < 4; s++) begin
      apply("R8 minus 128 signed", rnd128() | {16{8'h80}}, {16{8'h80}}, s, 1'b1, 1'b1, '0);
      apply("R8 minus 128 unsigned", rnd128(), {16{8'h80}}, s, 1'b0, 1'b1, '0);
    end
    apply("R1 upper amount bits ignored", 128'h1, {16{16'hFF01}}, 1, 1'b0, 1'b1, 128'h2);
    apply("R7 alternating lanes", '1, {8{16'h00F1, 16'h000F}}, 1, 1'b0, 1'b1,
          {8{16'h0001, 16'h8000}});
    apply("R6 narrow register", '1, '0, 0, 1'b0, 1'b0, {64'd0, {64{1'b1}}});

    held = result;
    @(negedge clk);
    check("R9 idle valid low", 128'(out_valid), 128'd0);
    check("R9 idle result held", result, held);

    for (int n = 0; n < 2000; n++) begin
      int s = int'($urandom % 4);
      apply_m((n % 2 == 0) ? "R5 random" : "R3 random", rnd128(), rnd_amounts(), s,
              1'($urandom), ($urandom % 4) != 0);
    end

    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R10 mid reset valid", 128'(out_valid), 128'd0);
    check("R10 mid reset result", result, '0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule